// File: doc/BRIEF.md
# Input-Transition Sequence Detector

This block watches a pair of single-bit inputs and raises its output when the pair reaches the combination `11` directly from the combination `01`. It is a clocked rendering of a fundamental-mode specification. The inputs are sampled on every clock edge. The block keeps the most recent sampled pair and the last sampled pair that differed from it. Holding the inputs steady leaves that earlier pair in place, so the output depends on the order in which the pair changes and not on how many cycles each value is held.

The pair is written `{x1,x2}`, with `x1` as the left bit. So `01` means x1=0, x2=1. After reset both remembered pairs are `00`, which matches the required idle input condition. The inputs are assumed to be synchronous to the clock already.

Top module: `pair_order_detector`

## Requirements
- R1: While `rst` is high, and at the first clock edge after it falls with `{x1,x2}`=00, `z` is 0. Reset loads both the current and the remembered preceding pair with 00.
- R2: One clock after the edge that samples `{x1,x2}`=11, `z` is 1 if the pair sampled at the edge before was 01.
- R3: If the pair reaches 11 from 00 or from 10, `z` stays 0.
- R4: While the pair stays at 11 after arriving from 01, `z` stays 1 for any number of cycles. Repeated samples of the same pair never overwrite the remembered preceding pair.
- R5: `z` is 0 one clock after any edge that samples a pair other than 11.
- R6: The remembered preceding pair changes only when the sampled pair differs from the current one. For example, 01 held for several cycles and then 11 still asserts `z`. The sequence 01, 00, 11 does not assert it.
- R7: `z` is 1 only when the current sampled pair is 11. It never depends on inputs that have not yet been sampled by a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| x1 | input | 1 | Left bit of the watched pair |
| x2 | input | 1 | Right bit of the watched pair |
| z | output | 1 | High while the pair is 11 after arriving from 01 |

## Verification
The assertions assume that `x1` and `x2` are stable across each rising clock edge. They also assume that the pair seen at an edge is exactly what the block records, with no metastable or glitching values. The bench meets this by changing both inputs only on falling edges. A fixed-seed random walk over the four pairs, with runs of held values, covers repeated samples and every transition into 11. Directed sequences cover 01→11, the transitions into 11 from 00 and from 10, long holds at 11, and a reset in the middle of a match.

// File: rtl/pod_pkg.sv
package pod_pkg;

    typedef logic [1:0] pair_t;

    localparam pair_t PAIR_IDLE = 2'b00;
    localparam pair_t PAIR_ARM  = 2'b01;
    localparam pair_t PAIR_FIRE = 2'b11;

    typedef struct packed {
        pair_t cur;
        pair_t prev;
    } hist_t;

    function automatic logic pair_differs(input pair_t a, input pair_t b);
        return a != b;
    endfunction

    function automatic logic is_match(input hist_t h);
        return (h.cur == PAIR_FIRE) && (h.prev == PAIR_ARM);
    endfunction

endpackage

// File: rtl/pod_sampler.sv
module pod_sampler
    import pod_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  x1,
    input  logic  x2,
    output pair_t cur_pair,
    output logic  changed
);
    pair_t sample_d;
    pair_t cur_q;

    assign sample_d = {x1, x2};

    always_ff @(posedge clk) begin
        if (rst) cur_q <= PAIR_IDLE;
        else     cur_q <= sample_d;
    end

    assign cur_pair = cur_q;
    assign changed  = pair_differs(sample_d, cur_q);
endmodule

// File: rtl/pod_history.sv
module pod_history
    import pod_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  pair_t cur_pair,
    input  logic  changed,
    output pair_t prev_pair
);
    pair_t prev_q;

    always_ff @(posedge clk) begin
        if (rst)          prev_q <= PAIR_IDLE;
        else if (changed) prev_q <= cur_pair;
    end

    assign prev_pair = prev_q;
endmodule

// File: rtl/pod_match.sv
module pod_match
    import pod_pkg::*;
(
    input  pair_t cur_pair,
    input  pair_t prev_pair,
    output logic  hit
);
    hist_t h;

    always_comb begin
        h.cur  = cur_pair;
        h.prev = prev_pair;
        hit    = is_match(h);
    end
endmodule

// File: rtl/pair_order_detector.sv
module pair_order_detector
    import pod_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic x1,
    input  logic x2,
    output logic z
);
    pair_t cur_pair;
    pair_t prev_pair;
    logic  changed;

    pod_sampler u_sampler (
        .clk      (clk),
        .rst      (rst),
        .x1       (x1),
        .x2       (x2),
        .cur_pair (cur_pair),
        .changed  (changed)
    );

    pod_history u_history (
        .clk       (clk),
        .rst       (rst),
        .cur_pair  (cur_pair),
        .changed   (changed),
        .prev_pair (prev_pair)
    );

    pod_match u_match (
        .cur_pair  (cur_pair),
        .prev_pair (prev_pair),
        .hit       (z)
    );
endmodule

// File: rtl/pod_checker.sv
module pod_checker (
    input logic clk,
    input logic rst,
    input logic x1,
    input logic x2,
    input logic z
);
    logic [1:0] pr;
    assign pr = {x1, x2};

    AST_RESET_QUIET: assert property (@(posedge clk) rst |=> !z); // R1

    AST_FIRE_FROM_ARM: assert property (@(posedge clk) disable iff (rst)
        (pr == 2'b11 && $past(pr) == 2'b01 && !$past(rst)) |=> z); // R2

    AST_NO_FIRE_OTHER: assert property (@(posedge clk) disable iff (rst)
        (pr == 2'b11 && ($past(pr) == 2'b00 || $past(pr) == 2'b10) && !$past(rst)) |=> !z); // R3

    AST_HOLD_FIRE: assert property (@(posedge clk) disable iff (rst)
        (z && pr == 2'b11) |=> z); // R4

    AST_DROP_ON_LEAVE: assert property (@(posedge clk) disable iff (rst)
        (pr != 2'b11) |=> !z); // R5

    AST_Z_NEEDS_FIRE: assert property (@(posedge clk) disable iff (rst)
        z |-> $past(pr) == 2'b11); // R7
endmodule

bind pair_order_detector pod_checker u_pod_checker (
    .clk (clk),
    .rst (rst),
    .x1  (x1),
    .x2  (x2),
    .z   (z)
);

// File: tb/pair_order_detector_bench.sv
module pair_order_detector_bench;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic x1 = 1'b0;
    logic x2 = 1'b0;
    logic z;

    int checks = 0;
    int errors = 0;
    logic [1:0] m_cur  = 2'b00;
    logic [1:0] m_prev = 2'b00;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    pair_order_detector u_pair_order_detector (
        .clk (clk), .rst (rst), .x1 (x1), .x2 (x2), .z (z)
    );

    function automatic logic exp_z(input logic [1:0] c, input logic [1:0] p);
        return (c == 2'b11) && (p == 2'b01);
    endfunction

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s z=%0b expected %0b (cur=%b prev=%b)", req, act, exp, m_cur, m_prev);
        end
    endtask

    // drive at falling edge, update model at rising edge, check at next falling edge
    task automatic step(input logic [1:0] p, input string req);
        x1 = p[1];
        x2 = p[0];
        @(posedge clk);
        if (rst) begin
            m_cur = 2'b00; m_prev = 2'b00;
        end else begin
            if (p != m_cur) m_prev = m_cur;
            m_cur = p;
        end
        @(negedge clk);
        check(req, z, exp_z(m_cur, m_prev));
    endtask

    task automatic do_reset();
        rst = 1'b1;
        step(2'b10, "R1");
        step(2'b01, "R1");
        rst = 1'b0;
        step(2'b00, "R1");
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        @(negedge clk);
        do_reset();

        // R2: direct arrival from 01
        step(2'b01, "R5");
        step(2'b11, "R2");
        // R4: hold at 11
        for (int i = 0; i < 6; i++) step(2'b11, "R4");
        // R5: leave 11
        step(2'b10, "R5");
        // R3: from 10 and from 00
        step(2'b11, "R3");
        step(2'b00, "R5");
        step(2'b11, "R3");
        // R6: hold 01 then 11
        step(2'b01, "R6");
        for (int i = 0; i < 4; i++) step(2'b01, "R6");
        step(2'b11, "R6");
        // R6: 01,00,11 does not fire
        step(2'b01, "R6");
        step(2'b00, "R6");
        step(2'b11, "R6");
        // R7: 11 -> 01 -> 11 fires again
        step(2'b01, "R7");
        step(2'b11, "R7");
        // R1: reset in the middle of a match
        rst = 1'b1;
        step(2'b11, "R1");
        rst = 1'b0;
        step(2'b11, "R1");
        step(2'b00, "R1");

        // random walk with held runs
        for (int n = 0; n < 3000; n++) begin
            logic [1:0] p;
            int hold;
            p = 2'($urandom_range(0, 3));
            hold = $urandom_range(1, 3);
            for (int k = 0; k < hold; k++)
                step(p, (p == 2'b11) ? "R2" : "R5");
        end

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule